// File: doc/BRIEF.md
# Time Base with Reference Compare

This block keeps a 64-bit time base and a 32-bit decrementer. Both advance on a clock-enable tick input, and both are controlled by one 16-bit control/status register. Two 32-bit reference registers are compared on every cycle against the lower time-base word. On a match, a sticky status flag is set. Software clears that flag by writing a one to it. If the matching enable is set, the block drives an interrupt request at a programmable 8-bit level.

Software uses a simple synchronous register bus. A write takes effect on the clock edge where `wr_en` is high. Reads are combinational from `addr`. An external freeze input can halt both counters, but only when the freeze control bit permits it. The decrementer reports each wrap through zero with a one-cycle pulse.

Top module: `tbref`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset:
  - the control/status register reads 0x0000;
  - the time base and the decrementer read 0;
  - both references read 0xFFFF_FFFF;
  - `irq_level` is 0 and `dec_wrap` is 0.
- R2: When enabled and not frozen, each cycle with `tick` high adds one to the 64-bit time base and subtracts one from the decrementer. When the lower word wraps from 0xFFFF_FFFF to 0, the upper word increases by one.
- R3: When a reference register equals the lower time-base word, its status bit is set on the following clock edge. The status bit for reference A is control bit 7 and the one for reference B is bit 6, counting bit 0 as the least significant bit.
- R4: A status bit clears only when a one is written to its position at address 0. Writing zero there leaves it unchanged. Both status bits may be cleared by a single write.
- R5: The freeze bit is control bit 1. When this bit and `freeze_in` are both high, the time base and the decrementer hold their values. Either one alone has no effect on counting.
- R6: The enable bit is control bit 0. When it is low, both counters hold their values regardless of `tick`.
- R7: `irq_level` equals control bits 15:8 in two cases:
  - reference A's status bit and its enable (bit 3) are both set;
  - reference B's status bit and its enable (bit 2) are both set.
  Otherwise `irq_level` is 0.
- R8: When a tick moves the decrementer from 0 to 0xFFFF_FFFF, `dec_wrap` is high for exactly the next cycle.
- R9: A match and a write-one-to-clear of the same status bit may fall in the same cycle. In that case the bit stays set.
- R10: Control bits 5:4 always read as zero and ignore writes.
- R11: The register map is:
  - address 0: control/status in bits 15:0;
  - address 1: lower time-base word, read/write;
  - address 2: upper time-base word, read only;
  - address 3: decrementer, read/write;
  - address 4: reference A;
  - address 5: reference B.

  Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable pulse |
| freeze_in | input | 1 | External freeze request |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_level | output | 8 | Interrupt request level, zero when idle |
| dec_wrap | output | 1 | One-cycle decrementer underflow pulse |

## Verification
The properties assume the following about the inputs:
- `addr` is a defined value whenever `wr_en` is high;
- a write to a counter may override a tick in the same cycle, so the hold and stability properties exclude cycles that write the register they observe.

The stimulus drives all bus signals and `tick` on falling edges. It never pulses `tick` during a register write, and it loads counters and references only while counting is disabled. Each counter movement is therefore caused by a single known tick.

// File: rtl/tbref.sv
module tbref #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         freeze_in,
  input  logic         wr_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [7:0]   irq_level,
  output logic         dec_wrap
);
  localparam logic [2:0] A_CTRL = 3'd0, A_TBLO = 3'd1, A_TBHI = 3'd2,
                         A_DEC = 3'd3, A_REFA = 3'd4, A_REFB = 3'd5;

  logic [7:0]   level;
  logic         sta_a, sta_b, en_a, en_b, frz, run;
  logic [W-1:0] tb_lo, tb_hi, dec, ref_a, ref_b;
  logic [15:0]  ctrl;
  logic         go, wctrl;

  assign go    = tick && run && !(frz && freeze_in);
  assign wctrl = wr_en && addr == A_CTRL;
  assign ctrl  = {level, sta_a, sta_b, 2'b00, en_a, en_b, frz, run};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {level, en_a, en_b, frz, run} <= '0;
      sta_a <= 1'b0;
      sta_b <= 1'b0;
    end else begin
      if (wctrl) {level, en_a, en_b, frz, run} <= {wdata[15:8], wdata[3:0]};
      sta_a <= (tb_lo == ref_a) || (sta_a && !(wctrl && wdata[7]));
      sta_b <= (tb_lo == ref_b) || (sta_b && !(wctrl && wdata[6]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_lo    <= '0;
      tb_hi    <= '0;
      dec      <= '0;
      ref_a    <= '1;
      ref_b    <= '1;
      dec_wrap <= 1'b0;
    end else begin
      dec_wrap <= go && dec == '0 && !(wr_en && addr == A_DEC);
      if (wr_en && addr == A_TBLO) tb_lo <= wdata;
      else if (go) begin
        tb_lo <= tb_lo + 1'b1;
        if (tb_lo == '1) tb_hi <= tb_hi + 1'b1;
      end
      if (wr_en && addr == A_DEC) dec <= wdata;
      else if (go) dec <= dec - 1'b1;
      if (wr_en && addr == A_REFA) ref_a <= wdata;
      if (wr_en && addr == A_REFB) ref_b <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {{(W-16){1'b0}}, ctrl};
      A_TBLO:  rdata = tb_lo;
      A_TBHI:  rdata = tb_hi;
      A_DEC:   rdata = dec;
      A_REFA:  rdata = ref_a;
      A_REFB:  rdata = ref_b;
      default: rdata = '0;
    endcase
  end

  assign irq_level = ((sta_a && en_a) || (sta_b && en_b)) ? level : 8'd0;
endmodule

// File: rtl/tbref_chk.sv
module tbref_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         freeze_in,
  input logic         wr_en,
  input logic [2:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [7:0]   irq_level,
  input logic         dec_wrap,
  input logic [W-1:0] tb_lo,
  input logic [W-1:0] dec,
  input logic [W-1:0] ref_a,
  input logic         sta_a,
  input logic         sta_b,
  input logic         en_a,
  input logic         en_b,
  input logic         frz,
  input logic         run
);
  p_match_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_lo == ref_a) |=> sta_a);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sta_a && !(wr_en && addr == 3'd0 && wdata[7])) |=> sta_a);

  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && freeze_in && !(wr_en && addr == 3'd3)) |=> $stable(dec));

  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && addr == 3'd1)) |=> $stable(tb_lo));

  p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 8'd0) |-> ((sta_a && en_a) || (sta_b && en_b)));

  p_wrap_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_wrap |-> (dec == '1));

  p_resv_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd0) |-> (rdata[5:4] == 2'b00));
endmodule

bind tbref tbref_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze_in(freeze_in), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .irq_level(irq_level),
  .dec_wrap(dec_wrap), .tb_lo(tb_lo), .dec(dec), .ref_a(ref_a),
  .sta_a(sta_a), .sta_b(sta_b), .en_a(en_a), .en_b(en_b), .frz(frz),
  .run(run)
);

// File: tb/tbref_tb.sv
module tbref_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        freeze_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  irq_level;
  logic        dec_wrap;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  tbref u_dut (.*);

  // {ctrl[15:0], 7'b0, freeze_in, ticks[3:0], expected_steps[3:0]}
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'h0001_0055,   // enabled
    32'h0000_0050,   // disabled
    32'h0003_0150,   // freeze bit and freeze input
    32'h0003_0055,   // freeze bit only
    32'h0001_0155,   // freeze input only
    32'h0002_0150    // disabled and frozen
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #1500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd1, v); chk("R1 tb_lo", v, 32'h0);
    rd(3'd3, v); chk("R1 dec", v, 32'h0);
    rd(3'd4, v); chk("R1 ref_a", v, 32'hFFFF_FFFF);
    chk("R1 irq", {24'h0, irq_level}, 32'h0);
    chk("R1 wrap", {31'h0, dec_wrap}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 ctrl after reset", v, 32'h0);

    for (int k = 0; k < NV; k++) begin
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h100);
      wr(3'd3, 32'h100);
      freeze_in = VEC[k][8];
      wr(3'd0, {16'h0, VEC[k][31:16]});
      ticks(int'(VEC[k][7:4]));
      rd(3'd1, v); chk("R2/R5/R6 tb_lo", v, 32'h100 + VEC[k][3:0]);
      rd(3'd3, v); chk("R2/R5/R6 dec", v, 32'h100 - VEC[k][3:0]);
      freeze_in = 1'b0;
    end

    wr(3'd0, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1);
    ticks(1);
    rd(3'd1, v); chk("R2 carry lo", v, 32'h0);
    rd(3'd2, v); chk("R2 carry hi R11", v, 32'h1);

    wr(3'd0, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h1);
    ticks(1);
    #1 chk("R8 wrap pulse", {31'h0, dec_wrap}, 32'h1);
    @(negedge clk);
    #1 chk("R8 wrap one cycle", {31'h0, dec_wrap}, 32'h0);
    rd(3'd3, v); chk("R8 dec value", v, 32'hFFFF_FFFF);

    wr(3'd0, 32'h0);
    wr(3'd4, 32'h200);
    rd(3'd4, v); chk("R11 ref_a readback", v, 32'h200);
    wr(3'd1, 32'h1FE);
    wr(3'd0, 32'h05C9);
    rd(3'd0, v); chk("R3 no early status", v, 32'h0509);
    ticks(2);
    @(negedge clk);
    rd(3'd0, v); chk("R3 status A set", v & 32'h80, 32'h80);
    chk("R7 irq level", {24'h0, irq_level}, 32'h05);
    ticks(1);
    rd(3'd0, v); chk("R4 sticky after mismatch", v & 32'h80, 32'h80);
    wr(3'd0, 32'h0501);
    chk("R7 masked irq", {24'h0, irq_level}, 32'h0);
    wr(3'd0, 32'h0508);
    rd(3'd0, v); chk("R4 zero write no effect", v & 32'h80, 32'h80);
    chk("R7 irq re-enabled", {24'h0, irq_level}, 32'h05);
    wr(3'd0, 32'h0588);
    rd(3'd0, v); chk("R4 clear A", v & 32'hC0, 32'h0);
    chk("R7 irq idle", {24'h0, irq_level}, 32'h0);

    wr(3'd0, 32'h0);
    wr(3'd1, 32'h300);
    wr(3'd4, 32'h300);
    wr(3'd5, 32'h300);
    @(negedge clk);
    wr(3'd0, 32'h80);
    rd(3'd0, v); chk("R9 set wins over clear", v & 32'h80, 32'h80);
    wr(3'd4, 32'h1);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'hC0);
    rd(3'd0, v); chk("R4 clear both", v & 32'hC0, 32'h0);

    wr(3'd0, 32'h30);
    rd(3'd0, v); chk("R10 reserved zero", v, 32'h0);
    rd(3'd7, v); chk("R11 unused address", v, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule